// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps the time of day and the calendar date. It counts a 32 kHz clock-enable strobe down to a one-second tick and carries that tick through seconds, minutes, hours, weekday, day of month, month and a two-digit year. The year runs from 0 to 99, so the calendar spans 100 years. Every field is held as a plain binary value in its own register. Software reads and writes these registers through a simple single-cycle register port. A write to any time field loads the value and restarts the sub-second divider, so the new time holds for one full second before it first advances.

A second set of registers holds the hour, minute and second at which an alarm fires. On a match the alarm sets a sticky flag and asserts the interrupt output. The flag stays set until software writes a one to clear it. An optional daylight-saving mode adjusts the hour automatically. On a fixed spring date the clock steps from 01:59:59 to 03:00:00. On a fixed autumn date it steps from 01:59:59 back to 01:00:00, and an internal marker stops that hour from repeating a second time.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read 00:00:00, weekday 1, day 1, month 1, year 0, with alarm fields 0, control 0, status 0, and `alarm_irq` is low.
- R2: The seconds field advances by one after every 2^DIV_BITS cycles in which `tick_en` is high; cycles with `tick_en` low do not count.
- R3: Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the date.
- R4: The weekday (address 3) counts 1 to 7 and wraps from 7 to 1 at each day carry.
- R5: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and after day 28 in February, or day 29 when year mod 4 is 0. The month then advances by one.
- R6: On a day carry out of month 12 the month becomes 1 and the year advances, and the year wraps from 99 to 0.
- R7: A write to a time register (addresses 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year) loads the value on the next edge and clears the divider, so a further 2^DIV_BITS enables pass before the next advance.
- R8: With control bit 0 set (daylight saving), a tick at 01:59:59 on the spring date (month SPRING_MON, day SPRING_DAY) gives 03:00:00.
- R9: With control bit 0 set, a tick at 01:59:59 on the autumn date (month AUTUMN_MON, day AUTUMN_DAY) gives 01:00:00 the first time only. The next time 01:59:59 is reached on that day, the clock advances normally to 02:00:00.
- R10: With control bit 0 clear, 01:59:59 advances to 02:00:00 on both adjustment dates.
- R11: With control bit 1 set (alarm enable), the first cycle in which the time equals the alarm second, minute and hour (addresses 7, 8, 9) sets status bit 0 (address 11) one cycle later and raises `alarm_irq`. Both stay high while the time moves on.
- R12: Writing 1 to status bit 0 clears the flag and drops `alarm_irq`, unless a new match begins in the same cycle.
- R13: With control bit 1 clear, reaching the alarm time sets neither the flag nor `alarm_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe at the 32 kHz time-base rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_irq | output | 1 | Alarm interrupt, high while the alarm flag is set |

## Verification
The counter chain is driven from times just before each kind of rollover: second only, the full midnight carry, weekday 7, 30-day and 31-day month ends, February in leap and non-leap years, and the year-99 New Year. Each case shows whether a different carry rule is applied at the right limit. The adjustment dates are run with daylight saving on and off, and the autumn hour is replayed. This separates the spring jump, the one-time fall-back and the normal advance. The alarm is taken through a near-miss second, the exact match, the seconds after it, a clear, and a match with the enable off. These show the compare, the stickiness and the gating as separate behaviours.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [3:0] {
      RA_SEC      = 4'd0,
      RA_MIN      = 4'd1,
      RA_HOUR     = 4'd2,
      RA_WDAY     = 4'd3,
      RA_MDAY     = 4'd4,
      RA_MON      = 4'd5,
      RA_YEAR     = 4'd6,
      RA_ALM_SEC  = 4'd7,
      RA_ALM_MIN  = 4'd8,
      RA_ALM_HOUR = 4'd9,
      RA_CTRL     = 4'd10,
      RA_STAT     = 4'd11
   } rtc_addr_e;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] mon;
      logic [4:0] mday;
      logic [2:0] wday;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } rtc_time_t;

   localparam rtc_time_t RTC_TIME_RESET = '{year: 7'd0, mon: 4'd1, mday: 5'd1,
                                            wday: 3'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

   function automatic logic [4:0] month_length(input logic [3:0] mon,
                                               input logic [6:0] year,
                                               input int unsigned leap_period);
      logic [4:0] len;
      case (mon)
         4'd2:                   len = ((year % leap_period) == 0) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: len = 5'd30;
         default:                len = 5'd31;
      endcase
      return len;
   endfunction

   function automatic logic is_time_addr(input logic [3:0] a);
      return a <= RA_YEAR;
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic clr,
   output logic sec_tick
);
   logic [DIV_BITS-1:0] cnt_q;

   assign sec_tick = tick_en && (&cnt_q) && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (tick_en) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
   import rtc_pkg::*;
#(
   parameter int          DST_HW      = 1,
   parameter int          SPRING_MON  = 3,
   parameter int          SPRING_DAY  = 26,
   parameter int          AUTUMN_MON  = 10,
   parameter int          AUTUMN_DAY  = 29,
   parameter int          YEAR_SPAN   = 100,
   parameter int unsigned LEAP_PERIOD = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       dst_en,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output rtc_time_t  now
);
   localparam logic [6:0] YEAR_LAST = 7'(YEAR_SPAN - 1);

   rtc_time_t now_q, nxt;
   logic      day_carry;
   logic      spring_hit, autumn_hit;
   logic      at_one_59_59;

   assign now          = now_q;
   assign at_one_59_59 = (now_q.hour == 5'd1) && (now_q.min == 6'd59) && (now_q.sec == 6'd59);

   generate
      if (DST_HW != 0) begin : g_dst
         logic fallback_done_q;
         assign spring_hit = dst_en && at_one_59_59 &&
                             (now_q.mon == 4'(SPRING_MON)) && (now_q.mday == 5'(SPRING_DAY));
         assign autumn_hit = dst_en && at_one_59_59 && !fallback_done_q &&
                             (now_q.mon == 4'(AUTUMN_MON)) && (now_q.mday == 5'(AUTUMN_DAY));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fallback_done_q <= 1'b0;
            end else if (sec_tick && autumn_hit) begin
               fallback_done_q <= 1'b1;
            end else if (day_carry) begin
               fallback_done_q <= 1'b0;
            end
         end
      end else begin : g_no_dst
         assign spring_hit = 1'b0;
         assign autumn_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt       = now_q;
      day_carry = 1'b0;
      if (sec_tick) begin
         if (spring_hit) begin
            nxt.hour = 5'd3;
            nxt.min  = 6'd0;
            nxt.sec  = 6'd0;
         end else if (autumn_hit) begin
            nxt.hour = 5'd1;
            nxt.min  = 6'd0;
            nxt.sec  = 6'd0;
         end else if (now_q.sec != 6'd59) begin
            nxt.sec = now_q.sec + 6'd1;
         end else begin
            nxt.sec = 6'd0;
            if (now_q.min != 6'd59) begin
               nxt.min = now_q.min + 6'd1;
            end else begin
               nxt.min = 6'd0;
               if (now_q.hour != 5'd23) begin
                  nxt.hour = now_q.hour + 5'd1;
               end else begin
                  nxt.hour  = 5'd0;
                  day_carry = 1'b1;
               end
            end
         end
      end
      if (day_carry) begin
         nxt.wday = (now_q.wday >= 3'd7) ? 3'd1 : now_q.wday + 3'd1;
         if (now_q.mday >= month_length(now_q.mon, now_q.year, LEAP_PERIOD)) begin
            nxt.mday = 5'd1;
            if (now_q.mon >= 4'd12) begin
               nxt.mon  = 4'd1;
               nxt.year = (now_q.year >= YEAR_LAST) ? 7'd0 : now_q.year + 7'd1;
            end else begin
               nxt.mon = now_q.mon + 4'd1;
            end
         end else begin
            nxt.mday = now_q.mday + 5'd1;
         end
      end
      if (wr_en) begin
         case (wr_addr)
            RA_SEC:  nxt.sec  = wr_data[5:0];
            RA_MIN:  nxt.min  = wr_data[5:0];
            RA_HOUR: nxt.hour = wr_data[4:0];
            RA_WDAY: nxt.wday = wr_data[2:0];
            RA_MDAY: nxt.mday = wr_data[4:0];
            RA_MON:  nxt.mon  = wr_data[3:0];
            RA_YEAR: nxt.year = wr_data[6:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q <= RTC_TIME_RESET;
      end else begin
         now_q <= nxt;
      end
   end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       alarm_en,
   input  logic [5:0] cur_sec,
   input  logic [5:0] cur_min,
   input  logic [4:0] cur_hour,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [5:0] alm_sec,
   output logic [5:0] alm_min,
   output logic [4:0] alm_hour,
   output logic       match,
   output logic       flag
);
   logic match_prev_q;
   logic flag_q;
   logic clr_req;

   assign match   = alarm_en && (cur_sec == alm_sec) && (cur_min == alm_min) &&
                    (cur_hour == alm_hour);
   assign clr_req = wr_en && (wr_addr == RA_STAT) && wr_data[0];
   assign flag    = flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_sec  <= '0;
         alm_min  <= '0;
         alm_hour <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_ALM_SEC:  alm_sec  <= wr_data[5:0];
            RA_ALM_MIN:  alm_min  <= wr_data[5:0];
            RA_ALM_HOUR: alm_hour <= wr_data[4:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_prev_q <= 1'b0;
         flag_q       <= 1'b0;
      end else begin
         match_prev_q <= match;
         if (match && !match_prev_q) begin
            flag_q <= 1'b1;
         end else if (clr_req) begin
            flag_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int          DIV_BITS    = 15,
   parameter int          DST_HW      = 1,
   parameter int          SPRING_MON  = 3,
   parameter int          SPRING_DAY  = 26,
   parameter int          AUTUMN_MON  = 10,
   parameter int          AUTUMN_DAY  = 29,
   parameter int          YEAR_SPAN   = 100,
   parameter int unsigned LEAP_PERIOD = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [3:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       alarm_irq
);
   generate
      if (DIV_BITS < 1 || DIV_BITS > 24) begin : g_bad_div
         $error("rtc_calendar: DIV_BITS must lie in 1..24");
      end
      if (SPRING_MON < 1 || SPRING_MON > 12 || AUTUMN_MON < 1 || AUTUMN_MON > 12) begin : g_bad_mon
         $error("rtc_calendar: adjustment months must lie in 1..12");
      end
      if (SPRING_DAY < 1 || SPRING_DAY > 28 || AUTUMN_DAY < 1 || AUTUMN_DAY > 28 + 3) begin : g_bad_day
         $error("rtc_calendar: adjustment days out of range");
      end
      if (YEAR_SPAN < 2 || YEAR_SPAN > 128) begin : g_bad_span
         $error("rtc_calendar: YEAR_SPAN must lie in 2..128");
      end
      if (LEAP_PERIOD < 1) begin : g_bad_leap
         $error("rtc_calendar: LEAP_PERIOD must be positive");
      end
   endgenerate

   rtc_time_t  now;
   logic       sec_tick;
   logic       time_wr;
   logic       dst_en_q, alarm_en_q;
   logic [5:0] alm_sec, alm_min;
   logic [4:0] alm_hour;
   logic       alarm_match;
   logic       alarm_flag;

   assign time_wr   = wr_en && is_time_addr(wr_addr);
   assign alarm_irq = alarm_flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_en_q   <= 1'b0;
         alarm_en_q <= 1'b0;
      end else if (wr_en && (wr_addr == RA_CTRL)) begin
         dst_en_q   <= wr_data[0];
         alarm_en_q <= wr_data[1];
      end
   end

   rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .clr      (time_wr),
      .sec_tick (sec_tick)
   );

   rtc_timekeeper #(
      .DST_HW      (DST_HW),
      .SPRING_MON  (SPRING_MON),
      .SPRING_DAY  (SPRING_DAY),
      .AUTUMN_MON  (AUTUMN_MON),
      .AUTUMN_DAY  (AUTUMN_DAY),
      .YEAR_SPAN   (YEAR_SPAN),
      .LEAP_PERIOD (LEAP_PERIOD)
   ) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .dst_en   (dst_en_q),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .now      (now)
   );

   rtc_alarm u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .alarm_en (alarm_en_q),
      .cur_sec  (now.sec),
      .cur_min  (now.min),
      .cur_hour (now.hour),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .alm_sec  (alm_sec),
      .alm_min  (alm_min),
      .alm_hour (alm_hour),
      .match    (alarm_match),
      .flag     (alarm_flag)
   );

   always_comb begin
      case (rd_addr)
         RA_SEC:      rd_data = {2'b0, now.sec};
         RA_MIN:      rd_data = {2'b0, now.min};
         RA_HOUR:     rd_data = {3'b0, now.hour};
         RA_WDAY:     rd_data = {5'b0, now.wday};
         RA_MDAY:     rd_data = {3'b0, now.mday};
         RA_MON:      rd_data = {4'b0, now.mon};
         RA_YEAR:     rd_data = {1'b0, now.year};
         RA_ALM_SEC:  rd_data = {2'b0, alm_sec};
         RA_ALM_MIN:  rd_data = {2'b0, alm_min};
         RA_ALM_HOUR: rd_data = {3'b0, alm_hour};
         RA_CTRL:     rd_data = {6'b0, alarm_en_q, dst_en_q};
         RA_STAT:     rd_data = {7'b0, alarm_flag};
         default:     rd_data = 8'h00;
      endcase
   end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [3:0] wr_addr,
   input logic [5:0] wr_low,
   input logic       sec_tick,
   input logic [5:0] sec,
   input logic [5:0] min,
   input logic [4:0] hour,
   input logic       alarm_en,
   input logic       alarm_match,
   input logic       alarm_irq
);
   logic clr_wr;
   assign clr_wr = wr_en && (wr_addr == 4'd11) && wr_low[0];

   // R2: a tick below second 59 adds exactly one second
   p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec < 6'd59) |=> (sec == $past(sec) + 6'd1));

   // R3: the last second of the day rolls to midnight
   p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && hour == 5'd23 && min == 6'd59 && sec == 6'd59) |=>
      (hour == 5'd0 && min == 6'd0 && sec == 6'd0));

   // R7: time holds without a tick or write
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour)));

   // R7: a seconds write lands on the next edge
   p_sec_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 4'd0) |=> (sec == $past(wr_low)));

   // R11: the interrupt stays high until cleared
   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_irq && !clr_wr) |=> alarm_irq);

   // R12: a clear without a match drops the interrupt
   p_irq_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !alarm_match) |=> !alarm_irq);

   // R13: a disabled alarm never raises the interrupt
   p_alarm_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_en && !alarm_irq) |=> !alarm_irq);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_low      (wr_data[5:0]),
   .sec_tick    (sec_tick),
   .sec         (now.sec),
   .min         (now.min),
   .hour        (now.hour),
   .alarm_en    (alarm_en_q),
   .alarm_match (alarm_match),
   .alarm_irq   (alarm_irq)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
   localparam int DIV_BITS = 2;
   localparam int EN_PER_SEC = 1 << DIV_BITS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       alarm_irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   rtc_calendar #(.DIV_BITS(DIV_BITS)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .alarm_irq(alarm_irq));

   task automatic chk(input string req, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input int exp);
      rd_addr = a;
      #1;
      chk(req, int'(rd_data), exp);
   endtask

   task automatic run_en(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic set_time(input int h, input int m, input int s,
                           input int wd, input int md, input int mo, input int yr);
      wr(4'd2, 8'(h)); wr(4'd1, 8'(m)); wr(4'd3, 8'(wd));
      wr(4'd4, 8'(md)); wr(4'd5, 8'(mo)); wr(4'd6, 8'(yr));
      wr(4'd0, 8'(s));
   endtask

   task automatic chk_hms(input string req, input int h, input int m, input int s);
      rd_chk(req, 4'd2, h); rd_chk(req, 4'd1, m); rd_chk(req, 4'd0, s);
   endtask

   task automatic chk_date(input string req, input int wd, input int md, input int mo, input int yr);
      rd_chk(req, 4'd3, wd); rd_chk(req, 4'd4, md); rd_chk(req, 4'd5, mo); rd_chk(req, 4'd6, yr);
   endtask

   task automatic t_reset_r1();
      chk_hms("R1", 0, 0, 0);
      chk_date("R1", 1, 1, 1, 0);
      for (int a = 7; a <= 11; a++) rd_chk("R1", 4'(a), 0);
      chk("R1 irq", int'(alarm_irq), 0);
   endtask

   task automatic t_tick_r2();
      wr(4'd0, 8'd10);
      run_en(EN_PER_SEC - 1);
      rd_chk("R2 before", 4'd0, 10);
      repeat (3) @(negedge clk);
      rd_chk("R2 idle", 4'd0, 10);
      run_en(1);
      rd_chk("R2 after", 4'd0, 11);
   endtask

   task automatic t_write_clear_r7();
      run_en(EN_PER_SEC - 2);
      wr(4'd0, 8'd20);
      rd_chk("R7 load", 4'd0, 20);
      run_en(EN_PER_SEC - 1);
      rd_chk("R7 divider cleared", 4'd0, 20);
      run_en(1);
      rd_chk("R7 advance", 4'd0, 21);
   endtask

   task automatic t_chain_r3();
      set_time(23, 59, 58, 3, 10, 5, 21);
      run_en(EN_PER_SEC);
      chk_hms("R3 sec", 23, 59, 59);
      run_en(EN_PER_SEC);
      chk_hms("R3 midnight", 0, 0, 0);
      chk_date("R3 date", 4, 11, 5, 21);
      set_time(10, 59, 59, 2, 3, 5, 21);
      run_en(EN_PER_SEC);
      chk_hms("R3 hour", 11, 0, 0);
   endtask

   task automatic t_wday_r4();
      set_time(23, 59, 59, 7, 12, 6, 21);
      run_en(EN_PER_SEC);
      chk_date("R4", 1, 13, 6, 21);
   endtask

   task automatic t_months_r5();
      set_time(23, 59, 59, 1, 30, 4, 21);
      run_en(EN_PER_SEC);
      chk_date("R5 30-day", 2, 1, 5, 21);
      set_time(23, 59, 59, 1, 30, 5, 21);
      run_en(EN_PER_SEC);
      chk_date("R5 31-day", 2, 31, 5, 21);
      set_time(23, 59, 59, 1, 28, 2, 23);
      run_en(EN_PER_SEC);
      chk_date("R5 feb common", 2, 1, 3, 23);
      set_time(23, 59, 59, 1, 28, 2, 24);
      run_en(EN_PER_SEC);
      chk_date("R5 feb leap 28", 2, 29, 2, 24);
      run_en(EN_PER_SEC * 86400 / 86400);
      set_time(23, 59, 59, 2, 29, 2, 24);
      run_en(EN_PER_SEC);
      chk_date("R5 feb leap 29", 3, 1, 3, 24);
   endtask

   task automatic t_year_r6();
      set_time(23, 59, 59, 5, 31, 12, 50);
      run_en(EN_PER_SEC);
      chk_date("R6 new year", 6, 1, 1, 51);
      set_time(23, 59, 59, 5, 31, 12, 99);
      run_en(EN_PER_SEC);
      chk_date("R6 century wrap", 6, 1, 1, 0);
   endtask

   task automatic t_spring_r8();
      wr(4'd10, 8'h01);
      set_time(1, 59, 59, 7, 26, 3, 22);
      run_en(EN_PER_SEC);
      chk_hms("R8 spring", 3, 0, 0);
   endtask

   task automatic t_autumn_r9();
      wr(4'd10, 8'h01);
      set_time(1, 59, 59, 7, 29, 10, 22);
      run_en(EN_PER_SEC);
      chk_hms("R9 fall back", 1, 0, 0);
      wr(4'd1, 8'd59);
      wr(4'd0, 8'd59);
      run_en(EN_PER_SEC);
      chk_hms("R9 no repeat", 2, 0, 0);
   endtask

   task automatic t_dst_off_r10();
      wr(4'd10, 8'h00);
      set_time(1, 59, 59, 7, 26, 3, 22);
      run_en(EN_PER_SEC);
      chk_hms("R10 spring off", 2, 0, 0);
      set_time(1, 59, 59, 1, 29, 10, 23);
      run_en(EN_PER_SEC);
      chk_hms("R10 autumn off", 2, 0, 0);
   endtask

   task automatic t_alarm_r11();
      wr(4'd10, 8'h02);
      wr(4'd7, 8'd5); wr(4'd8, 8'd30); wr(4'd9, 8'd12);
      set_time(12, 30, 3, 1, 1, 1, 30);
      run_en(EN_PER_SEC);
      @(negedge clk);
      chk("R11 near miss", int'(alarm_irq), 0);
      run_en(EN_PER_SEC);
      @(negedge clk);
      chk("R11 match irq", int'(alarm_irq), 1);
      rd_chk("R11 status", 4'd11, 1);
      run_en(2 * EN_PER_SEC);
      @(negedge clk);
      chk("R11 sticky", int'(alarm_irq), 1);
      chk_hms("R11 time", 12, 30, 7);
   endtask

   task automatic t_clear_r12();
      wr(4'd11, 8'h01);
      chk("R12 irq", int'(alarm_irq), 0);
      rd_chk("R12 status", 4'd11, 0);
   endtask

   task automatic t_alarm_off_r13();
      wr(4'd10, 8'h00);
      set_time(12, 30, 4, 1, 1, 1, 30);
      run_en(EN_PER_SEC);
      @(negedge clk);
      chk_hms("R13 time", 12, 30, 5);
      chk("R13 irq", int'(alarm_irq), 0);
      rd_chk("R13 status", 4'd11, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_tick_r2();
      t_write_clear_r7();
      t_chain_r3();
      t_wday_r4();
      t_months_r5();
      t_year_r6();
      t_spring_r8();
      t_autumn_r9();
      t_dst_off_r10();
      t_alarm_r11();
      t_clear_r12();
      t_alarm_off_r13();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule